// File: doc/BRIEF.md
# Video Standard Detector with Debounce

This block sorts an incoming standard-definition parallel video stream into one of eight formats. It measures two things: how many words arrive between successive line-start markers, and how many lines arrive between successive frame-start markers. The word count fixes the sampling structure (component 13.5 MHz, composite, widescreen 18 MHz, or single-link 4:4:4:4). The line count fixes the line system (525 or 625). The result goes out as a 4-bit standard code, a colour-format bit and a lock flag. The same values can be read back through a host register.

Reported results are debounced in two tiers. A new sampling structure within the current line system must be measured on eight consecutive lines before it is reported. A change of line system must be measured over four consecutive frames. A measurement that disagrees with the pending candidate restarts its confirmation. A host write can place the block in manual mode. In that mode the code and format bit come straight from the written value, and detection keeps running underneath.

Top module: `vsd_std_detect`

## Requirements
- R1: After reset, std_code is 0000, fmt_out is 0, locked is 1, manual mode is off and host_rdata is 0.
- R2: Code bit 2 is the line system (0 = 525, 1 = 625). Bits 1:0 are the structure. Words per line by structure, 525 then 625: 00 = 1716/1728, 01 = 910/1135, 10 = 2288/2304, 11 = 3432/3456. Bit 3 is 0 in automatic mode.
- R3: A line measurement is the number of word_en cycles from one trs_line cycle up to the next; trs_line coincides with the first word. A new structure is reported once eight consecutive valid line measurements agree on it, within 3 clocks of the marker that closes the eighth line.
- R4: A valid line or frame measurement that differs from both the reported value and the pending candidate restarts confirmation with itself as the only agreeing sample. A measurement equal to the reported value cancels any pending candidate.
- R5: A frame measurement is the number of trs_line cycles from one trs_frame cycle up to the next; trs_frame coincides with a trs_line. 525 lines selects code bit 2 = 0 and 625 selects 1. A new line system is reported after four consecutive agreeing frame measurements.
- R6: Word counts outside the R2 table, and line counts other than 525 or 625, neither advance nor clear confirmation.
- R7: A line measurement whose word count belongs to the line system that is not currently reported is ignored by structure confirmation.
- R8: locked is 1 exactly when neither the structure nor the line system has a pending candidate.
- R9: An identification word is accepted on an id_valid cycle when data_in[9] equals the XOR of data_in[8:0]. Bit data_in[2] of an accepted word is the RGB flag. In automatic mode, fmt_out shows the latched flag when the reported structure is 11, and 0 otherwise.
- R10: A host_we cycle loads host_wdata: bit 5 = manual, bit 4 = format bit, bits 3:0 = code. While manual is 1, std_code and fmt_out follow the written fields from the next cycle on.
- R11: host_rdata is {manual, fmt_out, std_code}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 10 | Video word, inspected on id_valid cycles |
| word_en | input | 1 | A word is present this cycle |
| trs_line | input | 1 | Decoded line-start marker, with the first word |
| trs_frame | input | 1 | Decoded frame-start marker, with a trs_line |
| id_valid | input | 1 | data_in holds an identification word |
| host_we | input | 1 | Host register write strobe |
| host_wdata | input | 6 | {manual, format bit, code[3:0]} |
| std_code | output | 4 | Reported standard code |
| fmt_out | output | 1 | RGB (1) / YCbCr (0) format bit |
| locked | output | 1 | No candidate pending |
| host_rdata | output | 6 | {manual, fmt_out, std_code} |

## Verification
Some rules are checked on every cycle by the assertions. Inside each confirmation unit, the reported value may change only on the sample that brings the candidate to its threshold. The agreement count stays below that threshold. A fresh disagreeing sample restarts the count at one. A manual-mode write shows up on the outputs on the following cycle. Other behaviour can only be shown by the bench scenarios. These include the exact word and line counts that count as valid, the ignoring of cross-system line lengths, interrupted and invalid-frame sequences, the acceptance rule for the identification word, and host read-back.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        CLS_422  = 2'b00,
        CLS_COMP = 2'b01,
        CLS_WIDE = 2'b10,
        CLS_4444 = 2'b11
    } cls_e;

    typedef struct packed {
        logic ok;
        logic pal;
        cls_e cls;
    } line_meas_t;

    localparam int unsigned NUM_CLS = 4;

    function automatic int unsigned words_per_line(input logic pal, input cls_e cls);
        int unsigned w;
        case (cls)
            CLS_422:  w = pal ? 1728 : 1716;
            CLS_COMP: w = pal ? 1135 : 910;
            CLS_WIDE: w = pal ? 2304 : 2288;
            default:  w = pal ? 3456 : 3432;
        endcase
        return w;
    endfunction

    function automatic line_meas_t classify_line(input int unsigned words);
        line_meas_t r;
        r = '{ok: 1'b0, pal: 1'b0, cls: CLS_422};
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < NUM_CLS; c++) begin
                if (words == words_per_line(p[0], cls_e'(c[1:0]))) begin
                    r.ok  = 1'b1;
                    r.pal = p[0];
                    r.cls = cls_e'(c[1:0]);
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/vsd_line_meter.sv
module vsd_line_meter
    import vsd_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       word_en,
    input  logic       trs_line,
    output logic       meas_valid,
    output logic       meas_pal,
    output cls_e       meas_cls
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] word_cnt_q;
    line_meas_t       res;

    always_comb res = classify_line(int'(word_cnt_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_cnt_q <= '0;
            meas_valid <= 1'b0;
            meas_pal   <= 1'b0;
            meas_cls   <= CLS_422;
        end else begin
            meas_valid <= 1'b0;
            if (trs_line) begin
                meas_valid <= res.ok;
                meas_pal   <= res.pal;
                meas_cls   <= res.cls;
                word_cnt_q <= word_en ? CNT_W'(1) : '0;
            end else if (word_en && word_cnt_q != CNT_MAX) begin
                word_cnt_q <= word_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vsd_frame_meter.sv
module vsd_frame_meter #(
    parameter int LINE_W     = 10,
    parameter int NTSC_LINES = 525,
    parameter int PAL_LINES  = 625
) (
    input  logic clk,
    input  logic rst,
    input  logic trs_line,
    input  logic trs_frame,
    output logic meas_valid,
    output logic meas_pal
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0] N_LINES  = LINE_W'(NTSC_LINES);
    localparam logic [LINE_W-1:0] P_LINES  = LINE_W'(PAL_LINES);

    logic [LINE_W-1:0] line_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt_q <= '0;
            meas_valid <= 1'b0;
            meas_pal   <= 1'b0;
        end else begin
            meas_valid <= 1'b0;
            if (trs_frame) begin
                meas_valid <= (line_cnt_q == N_LINES) || (line_cnt_q == P_LINES);
                meas_pal   <= (line_cnt_q == P_LINES);
                line_cnt_q <= LINE_W'(1);
            end else if (trs_line && line_cnt_q != LINE_MAX) begin
                line_cnt_q <= line_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vsd_confirm.sv
module vsd_confirm #(
    parameter int             W       = 2,
    parameter int             THRESH  = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         meas_valid,
    input  logic [W-1:0] meas_val,
    output logic [W-1:0] rep_val,
    output logic         pending
);
    localparam int             CW   = $clog2(THRESH + 1);
    localparam logic [CW-1:0]  LAST = CW'(THRESH - 1);

    logic [W-1:0]  cand_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_val <= RST_VAL;
            cand_q  <= RST_VAL;
            cnt_q   <= '0;
        end else if (meas_valid) begin
            if (meas_val == rep_val) begin
                cnt_q <= '0;
            end else if (cnt_q != '0 && meas_val == cand_q) begin
                if (cnt_q == LAST) begin
                    rep_val <= meas_val;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cand_q <= meas_val;
                cnt_q  <= CW'(1);
            end
        end
    end

    assign pending = (cnt_q != '0);

    // R3 R5
    rep_change_needs_threshold_chk: assert property (@(posedge clk) disable iff (rst)
        (rep_val != $past(rep_val)) |-> ($past(meas_valid) && $past(cnt_q) == LAST));

    // R3 R5
    count_below_threshold_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(THRESH));

    // R4
    new_candidate_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && meas_val != rep_val && (cnt_q == '0 || meas_val != cand_q))
        |=> (cnt_q == CW'(1) || THRESH == 1));

endmodule

// File: rtl/vsd_std_detect.sv
module vsd_std_detect
    import vsd_pkg::*;
#(
    parameter int WORD_W        = 10,
    parameter int CNT_W         = 12,
    parameter int LINE_W        = 10,
    parameter int LINE_CONFIRM  = 8,
    parameter int FRAME_CONFIRM = 4,
    parameter int NTSC_LINES    = 525,
    parameter int PAL_LINES     = 625,
    parameter int FMT_POS       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] data_in,
    input  logic              word_en,
    input  logic              trs_line,
    input  logic              trs_frame,
    input  logic              id_valid,
    input  logic              host_we,
    input  logic [5:0]        host_wdata,
    output logic [3:0]        std_code,
    output logic              fmt_out,
    output logic              locked,
    output logic [5:0]        host_rdata
);
    logic lm_valid, lm_pal;
    cls_e lm_cls;
    logic fm_valid, fm_pal;

    logic [1:0] rep_cls;
    logic [0:0] rep_pal;
    logic       cls_pend, fam_pend;
    logic       cls_feed;

    logic       man_q, hfmt_q, rgb_q;
    logic [3:0] hcode_q;
    logic       id_ok;

    vsd_line_meter #(.CNT_W(CNT_W)) u_line (
        .clk(clk), .rst(rst), .word_en(word_en), .trs_line(trs_line),
        .meas_valid(lm_valid), .meas_pal(lm_pal), .meas_cls(lm_cls)
    );

    vsd_frame_meter #(.LINE_W(LINE_W), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES)) u_frame (
        .clk(clk), .rst(rst), .trs_line(trs_line), .trs_frame(trs_frame),
        .meas_valid(fm_valid), .meas_pal(fm_pal)
    );

    assign cls_feed = lm_valid && (lm_pal == rep_pal[0]);

    vsd_confirm #(.W(2), .THRESH(LINE_CONFIRM), .RST_VAL(2'b00)) u_cls_conf (
        .clk(clk), .rst(rst), .meas_valid(cls_feed), .meas_val(lm_cls),
        .rep_val(rep_cls), .pending(cls_pend)
    );

    vsd_confirm #(.W(1), .THRESH(FRAME_CONFIRM), .RST_VAL(1'b0)) u_fam_conf (
        .clk(clk), .rst(rst), .meas_valid(fm_valid), .meas_val(fm_pal),
        .rep_val(rep_pal), .pending(fam_pend)
    );

    assign id_ok = id_valid && (data_in[WORD_W-1] == ^data_in[WORD_W-2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            man_q   <= 1'b0;
            hfmt_q  <= 1'b0;
            hcode_q <= 4'h0;
            rgb_q   <= 1'b0;
        end else begin
            if (host_we) begin
                man_q   <= host_wdata[5];
                hfmt_q  <= host_wdata[4];
                hcode_q <= host_wdata[3:0];
            end
            if (id_ok) rgb_q <= data_in[FMT_POS];
        end
    end

    always_comb begin
        if (man_q) begin
            std_code = hcode_q;
            fmt_out  = hfmt_q;
        end else begin
            std_code = {1'b0, rep_pal[0], rep_cls};
            fmt_out  = (rep_cls == 2'b11) && rgb_q;
        end
    end

    assign locked     = !cls_pend && !fam_pend;
    assign host_rdata = {man_q, fmt_out, std_code};

    // R10
    manual_write_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_wdata[5]) |=> (std_code == $past(host_wdata[3:0]) && fmt_out == $past(host_wdata[4])));

    // R2 R5
    system_bit_source_chk: assert property (@(posedge clk) disable iff (rst)
        (!man_q && $past(!man_q) && std_code[2] != $past(std_code[2])) |-> $past(fm_valid));

endmodule

// File: tb/vsd_std_detect_test.sv
module vsd_std_detect_test;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 6;
    localparam int ROW_WORDS [NROWS] = '{910, 910, 2288, 1716, 2288, 2288};
    localparam int ROW_N     [NROWS] = '{7,   1,   5,    1,    7,    1};
    localparam int ROW_CODE  [NROWS] = '{0,   1,   1,    1,    1,    2};
    localparam int ROW_LOCK  [NROWS] = '{0,   1,   0,    0,    0,    1};

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] data_in;
    logic       word_en, trs_line, trs_frame, id_valid, host_we;
    logic [5:0] host_wdata;
    logic [3:0] std_code;
    logic       fmt_out, locked;
    logic [5:0] host_rdata;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsd_std_detect uut (
        .clk(clk), .rst(rst), .data_in(data_in), .word_en(word_en),
        .trs_line(trs_line), .trs_frame(trs_frame), .id_valid(id_valid),
        .host_we(host_we), .host_wdata(host_wdata), .std_code(std_code),
        .fmt_out(fmt_out), .locked(locked), .host_rdata(host_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            word_en = 0; trs_line = 0; trs_frame = 0; id_valid = 0; host_we = 0;
        end
    endtask

    task automatic send_line(input int words, input bit frm);
        for (int i = 0; i < words; i++) begin
            @(negedge clk);
            word_en = 1; trs_line = (i == 0); trs_frame = (i == 0) && frm;
        end
    endtask

    task automatic send_lines(input int words, input int n);
        for (int k = 0; k < n; k++) send_line(words, 0);
        send_line(2, 0);
        idle(4);
    endtask

    task automatic send_frame(input int lines);
        for (int k = 0; k < lines; k++) send_line(2, k == 0);
    endtask

    task automatic close_frames();
        send_line(2, 1);
        idle(4);
    endtask

    task automatic host_write(input logic [5:0] v);
        @(negedge clk);
        host_we = 1; host_wdata = v;
        idle(2);
    endtask

    task automatic id_word(input logic [9:0] w);
        @(negedge clk);
        id_valid = 1; data_in = w;
        idle(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; data_in = 0; word_en = 0; trs_line = 0; trs_frame = 0;
        id_valid = 0; host_we = 0; host_wdata = 0;
        idle(3);
        rst = 0;
        idle(2);
        // R1 reset state
        check("R1 code", std_code, 0);
        check("R1 fmt", fmt_out, 0);
        check("R1 locked", locked, 1);
        check("R1 rdata", host_rdata, 0);

        // R2 R3 R4 R8: structure changes within the 525 system
        for (int r = 0; r < NROWS; r++) begin
            send_lines(ROW_WORDS[r], ROW_N[r]);
            check($sformatf("R3 R4 code row%0d", r), std_code, ROW_CODE[r]);
            check($sformatf("R8 locked row%0d", r), locked, ROW_LOCK[r]);
        end

        // R5: three 625-line frames are not enough
        send_frame(625); send_frame(625); send_frame(625);
        close_frames();
        check("R5 code after 3 frames", std_code, 2);
        check("R8 locked during frame confirm", locked, 0);
        send_frame(625);
        close_frames();
        check("R5 code after 4 frames", std_code, 6);
        check("R8 locked after frame confirm", locked, 1);

        // R2 R3: single link in 625 system
        send_lines(3456, 8);
        check("R2 R3 code 625 single link", std_code, 7);

        // R7: 525-system line lengths ignored while 625 reported
        send_lines(1716, 8);
        check("R7 code unchanged", std_code, 7);
        check("R7 locked unchanged", locked, 1);

        // R9: rejected then accepted id word
        id_word(10'h004);
        check("R9 rejected id", fmt_out, 0);
        id_word(10'h204);
        check("R9 accepted id", fmt_out, 1);
        check("R11 rdata auto", host_rdata, 6'b010111);

        // R6: invalid frame neither advances nor clears
        send_frame(525); send_frame(525); send_frame(600); send_frame(525);
        close_frames();
        check("R6 code held", std_code, 7);
        check("R6 locked pending", locked, 0);
        send_frame(525);
        close_frames();
        check("R6 code after 4 valid", std_code, 3);
        check("R9 fmt kept single link", fmt_out, 1);

        // R10 R11 manual mode
        host_write(6'b100101);
        check("R10 manual code", std_code, 5);
        check("R10 manual fmt", fmt_out, 0);
        check("R11 rdata manual", host_rdata, 6'b100101);
        host_write(6'b000000);
        check("R10 back to auto", std_code, 3);
        check("R11 rdata auto again", host_rdata, 6'b010011);

        // R1 reset again
        @(negedge clk); rst = 1;
        idle(2);
        rst = 0;
        idle(1);
        check("R1 code after reset", std_code, 0);
        check("R1 fmt after reset", fmt_out, 0);
        check("R1 locked after reset", locked, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule